// File: doc/BRIEF.md
# Sub-Pattern Tree Road Filter

This block sits behind a coarse associative pattern matcher and removes fake roads. Each coarse road names one superstrip per detector layer. It also points to a short list of finer sub-patterns: the leaves of a tree in which every leaf is one resolution bit deeper in each layer. Before any road of an event arrives, the full-resolution hits of that event are written into one occupancy bitmap per layer. The leaf table is written in advance through its own write port.

For every accepted road the controller reads the road's leaves one per clock cycle. A leaf word holds one extra bit per layer. Appending that bit to the road's coarse superstrip gives the fine superstrip to test in that layer's bitmap. The scan stops at the first leaf whose fine superstrips are all occupied. The road is then emitted with its identifier and the position of that leaf in its list. If no leaf matches, the road is dropped as fake. Surviving roads leave in the order they arrived.

The controller has two states. `ST_IDLE` accepts a road. A road with a non-zero count takes transition *start* to `ST_SCAN`, and a road with a zero count is dropped with no transition. `ST_SCAN` checks one leaf per cycle. It takes transition *hit* back to `ST_IDLE` and emits the road, or transition *exhausted* back to `ST_IDLE` after the last leaf, without output. Otherwise it takes transition *next* and stays in `ST_SCAN` to check the following leaf.

Top module: `subpattern_road_filter`

## Requirements
- R1: Asserting `hit_clr` empties all seven layer bitmaps at the next edge, and it wins over a `hit_we` in the same cycle. Otherwise `hit_we` sets bit `hit_ss` (a 5-bit fine superstrip) in the bitmap of layer `hit_layer` (0..6), and set bits persist until cleared.
- R2: `leaf_we` stores the 7-bit `leaf_wdata` at address `leaf_waddr` (0..63) of the leaf table. Bit l of a leaf word is the extra fine bit for layer l.
- R3: A leaf matches when, for every layer l, the bitmap of layer l has its bit set at the fine superstrip {coarse superstrip of layer l, leaf bit l}. The coarse superstrip of layer l is `in_coarse[4*l+3:4*l]`, and the fine superstrip equals 2*coarse + bit.
- R4: Leaves are read from addresses start, start+1, … (modulo 64), one per cycle, and the scan ends at the first match. `out_idx` is the 0-based position of that leaf in the road's list.
- R5: A road with `in_count` = 0 is dropped without output, and `in_ready` stays high in the following cycle.
- R6: Only the first 16 leaves of a list are examined. Leaves at positions 16 and above cannot make a road survive.
- R7: A road with no matching leaf among its examined leaves produces no output. `in_ready` returns high exactly count_eff cycles after acceptance, where count_eff is the count limited to 16.
- R8: A road is accepted on a clock edge where `in_valid` and `in_ready` are both high. If its first match is at position j, `out_valid` is high for exactly one cycle, starting j+1 cycles after the acceptance edge, with the road's `out_id`. `in_ready` is low from acceptance until that cycle. Surviving roads keep their input order.
- R9: After reset, `out_valid` is low, `in_ready` is high and all bitmaps are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_clr | input | 1 | Empty all layer bitmaps |
| hit_we | input | 1 | Write one fine hit |
| hit_layer | input | 3 | Layer of the fine hit |
| hit_ss | input | 5 | Fine superstrip of the hit |
| leaf_we | input | 1 | Write one leaf word |
| leaf_waddr | input | 6 | Leaf table address |
| leaf_wdata | input | 7 | Leaf word, one fine bit per layer |
| in_valid | input | 1 | Road offered |
| in_ready | output | 1 | Controller can take a road |
| in_id | input | 8 | Road identifier |
| in_coarse | input | 28 | Coarse superstrip per layer, 4 bits each |
| in_start | input | 6 | First leaf address of the road |
| in_count | input | 5 | Number of leaves in the list |
| out_valid | output | 1 | Surviving road, one-cycle pulse |
| out_id | output | 8 | Identifier of the surviving road |
| out_idx | output | 4 | Position of the first matching leaf |

## Verification
The assertions take for granted that hits and leaves are never written while a road is being scanned, because the bitmaps and the leaf table are read combinationally during the scan. They also take for granted that `hit_layer` stays below the layer count. The stimulus keeps to this. Every hit and leaf write is issued only after the bench has seen `in_ready` high and has received the previous road's result. Layers are drawn from 0 to 6 only. Random events are mixed with directed cases for a zero count, an over-long list, a wrapping start address and a clear that coincides with a write.

// File: rtl/rf_pkg.sv
package rf_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;
endpackage

// File: rtl/rf_leaf_table.sv
module rf_leaf_table #(
    parameter int LAYERS = 7,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [LAYERS-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [LAYERS-1:0] rdata
);
    logic [LAYERS-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rf_hit_bitmap.sv
module rf_hit_bitmap #(
    parameter int LAYERS = 7,
    parameter int FW     = 5,
    localparam int LW    = $clog2(LAYERS),
    localparam int MAPW  = 1 << FW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               we,
    input  logic [LW-1:0]      wlayer,
    input  logic [FW-1:0]      wss,
    input  logic [LAYERS*FW-1:0] probe,
    output logic               all_hit
);
    logic [LAYERS-1:0] layer_hit;

    for (genvar g = 0; g < LAYERS; g++) begin : g_layer
        logic [MAPW-1:0] map_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                map_q <= '0;
            end else if (clr) begin
                map_q <= '0;
            end else if (we && (wlayer == LW'(g))) begin
                map_q[wss] <= 1'b1;
            end
        end

        assign layer_hit[g] = map_q[probe[g*FW +: FW]];

        // R1: a clear leaves the layer empty
        a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (map_q == '0));

        // R1: a written hit is present after the edge
        a_r1_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (we && !clr && (wlayer == LW'(g))) |=> map_q[$past(wss)]);
    end

    assign all_hit = &layer_hit;
endmodule

// File: rtl/rf_scan_ctrl.sv
module rf_scan_ctrl
    import rf_pkg::*;
#(
    parameter int LAYERS     = 7,
    parameter int CW         = 4,
    parameter int AW         = 6,
    parameter int CNT_W      = 5,
    parameter int ID_W       = 8,
    parameter int MAX_LEAVES = 16,
    localparam int FW        = CW + 1,
    localparam int IDX_W     = $clog2(MAX_LEAVES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [ID_W-1:0]      in_id,
    input  logic [LAYERS*CW-1:0] in_coarse,
    input  logic [AW-1:0]        in_start,
    input  logic [CNT_W-1:0]     in_count,
    output logic [AW-1:0]        leaf_raddr,
    input  logic [LAYERS-1:0]    leaf_bits,
    output logic [LAYERS*FW-1:0] probe,
    input  logic                 leaf_hit,
    output logic                 out_valid,
    output logic [ID_W-1:0]      out_id,
    output logic [IDX_W-1:0]     out_idx
);
    scan_state_e state_q, state_d;

    logic [CNT_W-1:0]     cnt_eff;
    logic [CNT_W-1:0]     cnt_q;
    logic [CNT_W-1:0]     k_q;
    logic [AW-1:0]        start_q;
    logic [ID_W-1:0]      id_q;
    logic [LAYERS*CW-1:0] coarse_q;
    logic                 last_leaf;

    assign cnt_eff   = (in_count > CNT_W'(MAX_LEAVES)) ? CNT_W'(MAX_LEAVES) : in_count;
    assign last_leaf = ((k_q + CNT_W'(1)) == cnt_q);
    assign in_ready  = (state_q == ST_IDLE);
    assign leaf_raddr = start_q + AW'(k_q);

    for (genvar g = 0; g < LAYERS; g++) begin : g_probe
        assign probe[g*FW +: FW] = {coarse_q[g*CW +: CW], leaf_bits[g]};
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid && (in_count != '0)) state_d = ST_SCAN;
            ST_SCAN: if (leaf_hit || last_leaf)        state_d = ST_IDLE;
            default:                                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_id    <= '0;
            out_idx   <= '0;
            cnt_q     <= '0;
            k_q       <= '0;
            start_q   <= '0;
            id_q      <= '0;
            coarse_q  <= '0;
        end else begin
            out_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        start_q  <= in_start;
                        cnt_q    <= cnt_eff;
                        id_q     <= in_id;
                        coarse_q <= in_coarse;
                        k_q      <= '0;
                    end
                end
                ST_SCAN: begin
                    if (leaf_hit) begin
                        out_valid <= 1'b1;
                        out_id    <= id_q;
                        out_idx   <= k_q[IDX_W-1:0];
                    end else begin
                        k_q <= k_q + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // R6: the scan position never reaches the limited count
    a_r6_scan_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> ((k_q < cnt_q) && (cnt_q <= CNT_W'(MAX_LEAVES))));

    // R8: a surviving road is a single-cycle pulse
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R5: a zero-count road leaves the controller ready
    a_r5_zero_count_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid && (in_count == '0)) |=> (in_ready && !out_valid));

    // R4: a matching leaf ends the scan and emits the road
    a_r4_first_match_stops: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SCAN) && leaf_hit) |=> (in_ready && out_valid));

    // R7: the last unmatched leaf ends the scan silently
    a_r7_miss_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SCAN) && !leaf_hit && last_leaf) |=> (in_ready && !out_valid));
endmodule

// File: rtl/subpattern_road_filter.sv
module subpattern_road_filter #(
    parameter int LAYERS     = 7,
    parameter int CW         = 4,
    parameter int LEAF_DEPTH = 64,
    parameter int CNT_W      = 5,
    parameter int ID_W       = 8,
    parameter int MAX_LEAVES = 16,
    localparam int FW        = CW + 1,
    localparam int AW        = $clog2(LEAF_DEPTH),
    localparam int LW        = $clog2(LAYERS),
    localparam int IDX_W     = $clog2(MAX_LEAVES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit_clr,
    input  logic                 hit_we,
    input  logic [LW-1:0]        hit_layer,
    input  logic [FW-1:0]        hit_ss,
    input  logic                 leaf_we,
    input  logic [AW-1:0]        leaf_waddr,
    input  logic [LAYERS-1:0]    leaf_wdata,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [ID_W-1:0]      in_id,
    input  logic [LAYERS*CW-1:0] in_coarse,
    input  logic [AW-1:0]        in_start,
    input  logic [CNT_W-1:0]     in_count,
    output logic                 out_valid,
    output logic [ID_W-1:0]      out_id,
    output logic [IDX_W-1:0]     out_idx
);
    logic [AW-1:0]        leaf_raddr;
    logic [LAYERS-1:0]    leaf_bits;
    logic [LAYERS*FW-1:0] probe;
    logic                 leaf_hit;

    rf_leaf_table #(.LAYERS(LAYERS), .DEPTH(LEAF_DEPTH)) u_leaves (
        .clk   (clk),
        .we    (leaf_we),
        .waddr (leaf_waddr),
        .wdata (leaf_wdata),
        .raddr (leaf_raddr),
        .rdata (leaf_bits)
    );

    rf_hit_bitmap #(.LAYERS(LAYERS), .FW(FW)) u_hits (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hit_clr),
        .we      (hit_we),
        .wlayer  (hit_layer),
        .wss     (hit_ss),
        .probe   (probe),
        .all_hit (leaf_hit)
    );

    rf_scan_ctrl #(
        .LAYERS(LAYERS), .CW(CW), .AW(AW), .CNT_W(CNT_W),
        .ID_W(ID_W), .MAX_LEAVES(MAX_LEAVES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_id      (in_id),
        .in_coarse  (in_coarse),
        .in_start   (in_start),
        .in_count   (in_count),
        .leaf_raddr (leaf_raddr),
        .leaf_bits  (leaf_bits),
        .probe      (probe),
        .leaf_hit   (leaf_hit),
        .out_valid  (out_valid),
        .out_id     (out_id),
        .out_idx    (out_idx)
    );

    // R1, R2: tables are not rewritten while a road is being scanned
    a_r2_no_load_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (!hit_we && !hit_clr && !leaf_we));

    // R1: only existing layers are addressed
    a_r1_layer_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        hit_we |-> (int'(hit_layer) < LAYERS));
endmodule

// File: tb/sim_subpattern_road_filter.sv
module sim_subpattern_road_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hit_clr = 1'b0, hit_we = 1'b0;
    logic [2:0]  hit_layer = '0;
    logic [4:0]  hit_ss = '0;
    logic        leaf_we = 1'b0;
    logic [5:0]  leaf_waddr = '0;
    logic [6:0]  leaf_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_id = '0;
    logic [27:0] in_coarse = '0;
    logic [5:0]  in_start = '0;
    logic [4:0]  in_count = '0;
    logic        out_valid;
    logic [7:0]  out_id;
    logic [3:0]  out_idx;

    int checks = 0, fails = 0, cyc = 0;
    logic [31:0] bm [7];
    logic [6:0]  leaf_m [64];
    int q_id[$], q_idx[$], q_cyc[$];

    subpattern_road_filter u0 (.*);

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // output monitor: order, identifier, position and cycle (R4, R8)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_id.size() == 0) begin
                check(1'b0, "R7 unexpected surviving road", int'(out_id), -1);
            end else begin
                check(int'(out_id) == q_id[0], "R8 road order", int'(out_id), q_id[0]);
                check(int'(out_idx) == q_idx[0], "R4 first matching leaf", int'(out_idx), q_idx[0]);
                check(cyc == q_cyc[0], "R8 output cycle", cyc, q_cyc[0]);
                void'(q_id.pop_front()); void'(q_idx.pop_front()); void'(q_cyc.pop_front());
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    function automatic int ref_match(input logic [27:0] co, input int start, input int cnt);
        int eff = (cnt > 16) ? 16 : cnt;
        for (int j = 0; j < eff; j++) begin
            logic [6:0] w = leaf_m[(start + j) % 64];
            bit ok = 1'b1;
            for (int l = 0; l < 7; l++) begin
                logic [4:0] f = {co[l*4 +: 4], w[l]};
                if (!bm[l][f]) ok = 1'b0;
            end
            if (ok) return j;
        end
        return -1;
    endfunction

    task automatic clear_hits(input bit with_write, input int l, input int s);
        @(negedge clk);
        hit_clr = 1'b1; hit_we = with_write; hit_layer = 3'(l); hit_ss = 5'(s);
        @(negedge clk);
        hit_clr = 1'b0; hit_we = 1'b0;
        for (int i = 0; i < 7; i++) bm[i] = '0;
    endtask

    task automatic put_hit(input int l, input int s);
        @(negedge clk);
        hit_we = 1'b1; hit_layer = 3'(l); hit_ss = 5'(s);
        @(negedge clk);
        hit_we = 1'b0;
        bm[l][s] = 1'b1;
    endtask

    task automatic put_leaf(input int a, input logic [6:0] w);
        @(negedge clk);
        leaf_we = 1'b1; leaf_waddr = 6'(a); leaf_wdata = w;
        @(negedge clk);
        leaf_we = 1'b0;
        leaf_m[a] = w;
    endtask

    task automatic send_road(input int id, input logic [27:0] co, input int start, input int cnt);
        int j, eff, acc, busy;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_id = 8'(id); in_coarse = co;
        in_start = 6'(start); in_count = 5'(cnt);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        acc = cyc;
        j = ref_match(co, start, cnt);
        eff = (cnt > 16) ? 16 : cnt;
        if (cnt == 0) begin
            check(in_ready == 1'b1, "R5 zero count keeps ready", int'(in_ready), 1);
        end else begin
            check(in_ready == 1'b0, "R8 busy after accept", int'(in_ready), 0);
            if (j >= 0) begin
                q_id.push_back(id); q_idx.push_back(j); q_cyc.push_back(acc + 1 + j);
                busy = j + 1;
            end else begin
                busy = eff;
            end
            repeat (busy) @(negedge clk);
            check(in_ready == 1'b1, (j >= 0) ? "R8 ready after match" : "R7 ready after miss",
                  int'(in_ready), 1);
            if (j < 0) check(q_id.size() == 0, "R7 no output for fake road", q_id.size(), 0);
        end
    endtask

    initial begin
        logic [27:0] zero_co = '0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 7; i++) bm[i] = '0;
        for (int a = 0; a < 64; a++) leaf_m[a] = '0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R9 in_ready after reset", int'(in_ready), 1);

        for (int a = 0; a < 64; a++) put_leaf(a, 7'h00);
        // R9: bitmaps empty after reset, so nothing survives
        send_road(1, zero_co, 0, 3);

        // R3: hit at fine superstrip 2*coarse+bit in every layer
        for (int l = 0; l < 7; l++) put_hit(l, 1);
        put_leaf(10, 7'h00); put_leaf(11, 7'h3F); put_leaf(12, 7'h7F);
        send_road(2, zero_co, 10, 3);            // R4: match at position 2
        send_road(3, zero_co, 0, 0);             // R5: zero count dropped
        send_road(4, zero_co, 10, 2);            // R7: no match in list

        // R6: a match at position 17 is beyond the limit
        for (int a = 20; a < 40; a++) put_leaf(a, 7'h00);
        put_leaf(37, 7'h7F);
        send_road(5, zero_co, 20, 20);
        put_leaf(35, 7'h7F);                     // position 15 is inside the limit
        send_road(6, zero_co, 20, 20);

        // R4: address wraps modulo 64
        put_leaf(62, 7'h00); put_leaf(63, 7'h00); put_leaf(0, 7'h00); put_leaf(1, 7'h7F);
        send_road(7, zero_co, 62, 4);

        // R1: clear wins over a simultaneous write
        clear_hits(1'b1, 0, 1);
        send_road(8, zero_co, 10, 3);
        // R2, R3: distinct coarse values per layer
        for (int l = 0; l < 7; l++) put_hit(l, 2 * l + (l % 2));
        put_leaf(50, 7'b0101010);
        send_road(9, 28'h6543210, 50, 1);

        // random events
        for (int ev = 0; ev < 6; ev++) begin
            clear_hits(1'b0, 0, 0);
            for (int l = 0; l < 7; l++)
                for (int s = 0; s < 32; s++)
                    if ($urandom_range(3) != 0) put_hit(l, s);
            for (int a = 0; a < 64; a++) put_leaf(a, 7'($urandom()));
            for (int r = 0; r < 40; r++)
                send_road(16 + (ev * 40 + r) % 200, 28'($urandom()),
                          $urandom_range(63), $urandom_range(20));
        end

        repeat (4) @(negedge clk);
        check(q_id.size() == 0, "R8 all expected roads emitted", q_id.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule